// File: doc/BRIEF.md
# Serial NAND Feature Register Target

This block is the device side of the feature-register path in a serial NAND flash model. A host on a single-lane serial bus (chip select, clock and one data line in each direction, clock idling low) sends a one-byte opcode. For a register access it then sends a one-byte register address and one data byte. The block keeps three feature registers: a block-lock register, a configuration register and a status register. It answers reads by shifting a byte back out and accepts writes to the registers the host may change.

The bus pins are brought into the local clock domain through a synchronizer. Bus clock edges are found by edge detection against the local clock. The local core (array controller, ECC engine) drives the dynamic part of the status register. It holds busy while an operation runs, raises one-cycle pulses to record an erase or program failure, and loads the two-bit ECC outcome of the last page read. The lock byte, the full configuration byte and its decoded enables, and the sticky status fields are brought out to the core as plain outputs.

Top module: `nand_feat_target`

## Requirements
- R1: After the synchronous reset, the lock register holds LOCK_RST (default 0x38) and the configuration register holds CFG_RST (default 0x10). The fail bits and the ECC field are 0 and the serial output is 0.
- R2: Opcode 0x0F followed by an address byte returns that register's byte. It is shifted out most significant bit first, one bit per falling bus clock edge, starting with the first falling edge after the address byte's last rising edge. The host samples on rising edges.
- R3: Opcode 0x1F with address 0xA0 writes the data byte into the lock register. The value shows on lock_q and reads back unchanged. 0x00 means nothing is locked.
- R4: Opcode 0x1F with address 0xB0 writes the configuration register. Bit 6 drives cfg_otp_en, bit 4 drives cfg_ecc_en and bit 0 drives cfg_quad_en.
- R5: A read of address 0xC0 returns the status byte. Bit 0 is busy, bit 2 is erase failure, bit 3 is program failure and bits 5:4 are the ECC outcome (0 clean, 1 corrected, 2 uncorrectable). Bits 7:6 and bit 1 read 0. Busy is taken from core_busy when the address byte completes.
- R6: A set-feature access to address 0xC0 leaves the status register unchanged.
- R7: Any other address reads as 0x00, and a write to it changes no register.
- R8: A core_erase_fail or core_prog_fail pulse sets its sticky status bit on the next clock. A core_ecc_load pulse copies core_ecc_val into the ECC field on the next clock.
- R9: Opcode 0xFF clears both fail bits and the ECC field and leaves the lock and configuration registers unchanged. A core event in the same cycle wins over the clear.
- R10: If chip select rises before all eight bits of a byte have been clocked in, nothing is updated. The next transaction starts again from its opcode.
- R11: After any other opcode the rest of the transaction is ignored: no register changes and the serial output stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Bus clock from host, idles low |
| spi_cs_n | input | 1 | Bus chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| core_busy | input | 1 | Core operation in progress |
| core_erase_fail | input | 1 | Pulse: erase failed |
| core_prog_fail | input | 1 | Pulse: program failed |
| core_ecc_load | input | 1 | Pulse: load ECC outcome |
| core_ecc_val | input | 2 | ECC outcome to load |
| lock_q | output | 8 | Lock register |
| cfg_q | output | 8 | Configuration register |
| cfg_otp_en | output | 1 | OTP area enabled |
| cfg_ecc_en | output | 1 | On-die ECC enabled |
| cfg_quad_en | output | 1 | Four-lane mode enabled |
| stat_erase_fail | output | 1 | Sticky erase failure |
| stat_prog_fail | output | 1 | Sticky program failure |
| stat_ecc | output | 2 | ECC outcome field |

## Verification
The bench aims at the cases where the address decode and the bit timing are easy to get wrong. A design that treats status as writable returns the host's 0xFF after a write to 0xC0, where 0x1C is expected. A design that decodes only some address bits lets the write to 0x90 land in a real register. A reply that is off by one falling edge comes back shifted by one bit. The bench also drops chip select four bits into a data byte, where a design that commits partial bytes corrupts the lock register. It sends the 0xFF opcode and checks that configuration survives it while the fail and ECC fields clear, and it sends an unknown opcode followed by a valid-looking address and data.

// File: rtl/nfr_pkg.sv
package nfr_pkg;
    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] OP_GET  = 8'h0F;
    localparam logic [BYTE_W-1:0] OP_SET  = 8'h1F;
    localparam logic [BYTE_W-1:0] OP_WIPE = 8'hFF;

    localparam logic [BYTE_W-1:0] ADR_LOCK = 8'hA0;
    localparam logic [BYTE_W-1:0] ADR_CFG  = 8'hB0;
    localparam logic [BYTE_W-1:0] ADR_STAT = 8'hC0;

    localparam int CFG_OTP_BIT  = 6;
    localparam int CFG_ECC_BIT  = 4;
    localparam int CFG_QUAD_BIT = 0;

    typedef enum logic [1:0] {
        ECC_CLEAN  = 2'd0,
        ECC_FIXED  = 2'd1,
        ECC_UNCORR = 2'd2
    } ecc_res_e;

    typedef enum logic [1:0] {
        PH_CMD,
        PH_ADDR,
        PH_DATA,
        PH_IDLE
    } phase_e;

    typedef struct packed {
        logic [1:0] ecc;
        logic       prog_fail;
        logic       erase_fail;
    } stat_t;

    function automatic logic [BYTE_W-1:0] pack_status(input stat_t s, input logic busy);
        return {2'b00, s.ecc, s.prog_fail, s.erase_fail, 1'b0, busy};
    endfunction
endpackage

// File: rtl/nfr_sync.sv
module nfr_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) pipe[0] <= RST_VAL;
                    else     pipe[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) pipe[s] <= RST_VAL;
                    else     pipe[s] <= pipe[s-1];
                end
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/nfr_regfile.sv
module nfr_regfile
    import nfr_pkg::*;
#(
    parameter logic [BYTE_W-1:0] LOCK_RST = 8'h38,
    parameter logic [BYTE_W-1:0] CFG_RST  = 8'h10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              clr_cmd,
    input  logic              core_busy,
    input  logic              core_erase_fail,
    input  logic              core_prog_fail,
    input  logic              core_ecc_load,
    input  logic [1:0]        core_ecc_val,
    input  logic [BYTE_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic [BYTE_W-1:0] lock_q,
    output logic [BYTE_W-1:0] cfg_q,
    output stat_t             stat_q
);
    stat_t stat_nx;

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q <= LOCK_RST;
            cfg_q  <= CFG_RST;
        end else if (wr_en) begin
            if (wr_addr == ADR_LOCK) lock_q <= wr_data;
            if (wr_addr == ADR_CFG)  cfg_q  <= wr_data;
        end
    end

    // Clear from the wipe opcode first, core events layered on top.
    always_comb begin
        stat_nx = stat_q;
        if (clr_cmd) stat_nx = '0;
        if (core_erase_fail) stat_nx.erase_fail = 1'b1;
        if (core_prog_fail)  stat_nx.prog_fail  = 1'b1;
        if (core_ecc_load)   stat_nx.ecc        = core_ecc_val;
    end

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '{ecc: ECC_CLEAN, default: 1'b0};
        else     stat_q <= stat_nx;
    end

    always_comb begin
        unique case (rd_addr)
            ADR_LOCK: rd_data = lock_q;
            ADR_CFG:  rd_data = cfg_q;
            ADR_STAT: rd_data = pack_status(stat_q, core_busy);
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/nand_feat_target.sv
module nand_feat_target
    import nfr_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter logic [BYTE_W-1:0] LOCK_RST    = 8'h38,
    parameter logic [BYTE_W-1:0] CFG_RST     = 8'h10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic              core_busy,
    input  logic              core_erase_fail,
    input  logic              core_prog_fail,
    input  logic              core_ecc_load,
    input  logic [1:0]        core_ecc_val,
    output logic [BYTE_W-1:0] lock_q,
    output logic [BYTE_W-1:0] cfg_q,
    output logic              cfg_otp_en,
    output logic              cfg_ecc_en,
    output logic              cfg_quad_en,
    output logic              stat_erase_fail,
    output logic              stat_prog_fail,
    output logic [1:0]        stat_ecc
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    logic              sclk_s, cs_s, mosi_s, sclk_d;
    logic              sclk_rise, sclk_fall, byte_done;
    phase_e            phase;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-2:0] rx_sh;
    logic [BYTE_W-1:0] rx_byte, addr_q, tx_sh, rd_data;
    logic              is_rd, miso_q;
    logic              wr_en, rst_cmd;
    logic [BYTE_W-1:0] wr_addr;
    stat_t             stat_q;

    nfr_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({spi_sclk, spi_cs_n, spi_mosi}),
        .q   ({sclk_s, cs_s, mosi_s})
    );

    always_ff @(posedge clk) begin
        if (rst) sclk_d <= 1'b0;
        else     sclk_d <= sclk_s;
    end

    assign sclk_rise = sclk_s & ~sclk_d & ~cs_s;
    assign sclk_fall = ~sclk_s & sclk_d & ~cs_s;
    assign rx_byte   = {rx_sh, mosi_s};
    assign byte_done = sclk_rise && (bit_cnt == LAST_BIT);
    assign wr_en     = byte_done && (phase == PH_DATA) && !is_rd;
    assign wr_addr   = addr_q;
    assign rst_cmd   = byte_done && (phase == PH_CMD) && (rx_byte == OP_WIPE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_CMD;
            bit_cnt <= '0;
            rx_sh   <= '0;
            is_rd   <= 1'b0;
            addr_q  <= '0;
            tx_sh   <= '0;
            miso_q  <= 1'b0;
        end else if (cs_s) begin
            phase   <= PH_CMD;
            bit_cnt <= '0;
            is_rd   <= 1'b0;
            tx_sh   <= '0;
            miso_q  <= 1'b0;
        end else begin
            if (sclk_rise) begin
                rx_sh   <= rx_byte[BYTE_W-2:0];
                bit_cnt <= bit_cnt + 1'b1;
                if (byte_done) begin
                    unique case (phase)
                        PH_CMD: begin
                            if (rx_byte == OP_GET) begin
                                phase <= PH_ADDR;
                                is_rd <= 1'b1;
                            end else if (rx_byte == OP_SET) begin
                                phase <= PH_ADDR;
                                is_rd <= 1'b0;
                            end else begin
                                phase <= PH_IDLE;
                            end
                        end
                        PH_ADDR: begin
                            addr_q <= rx_byte;
                            phase  <= PH_DATA;
                            if (is_rd) tx_sh <= rd_data;
                        end
                        PH_DATA: phase <= PH_IDLE;
                        default: phase <= PH_IDLE;
                    endcase
                end
            end
            if (sclk_fall) begin
                if (phase == PH_DATA && is_rd) begin
                    miso_q <= tx_sh[BYTE_W-1];
                    tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
                end else begin
                    miso_q <= 1'b0;
                end
            end
        end
    end

    nfr_regfile #(.LOCK_RST(LOCK_RST), .CFG_RST(CFG_RST)) u_regs (
        .clk             (clk),
        .rst             (rst),
        .wr_en           (wr_en),
        .wr_addr         (wr_addr),
        .wr_data         (rx_byte),
        .clr_cmd         (rst_cmd),
        .core_busy       (core_busy),
        .core_erase_fail (core_erase_fail),
        .core_prog_fail  (core_prog_fail),
        .core_ecc_load   (core_ecc_load),
        .core_ecc_val    (core_ecc_val),
        .rd_addr         (rx_byte),
        .rd_data         (rd_data),
        .lock_q          (lock_q),
        .cfg_q           (cfg_q),
        .stat_q          (stat_q)
    );

    assign spi_miso        = miso_q;
    assign cfg_otp_en      = cfg_q[CFG_OTP_BIT];
    assign cfg_ecc_en      = cfg_q[CFG_ECC_BIT];
    assign cfg_quad_en     = cfg_q[CFG_QUAD_BIT];
    assign stat_erase_fail = stat_q.erase_fail;
    assign stat_prog_fail  = stat_q.prog_fail;
    assign stat_ecc        = stat_q.ecc;
endmodule

// File: rtl/nfr_checker.sv
module nfr_checker
    import nfr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              core_erase_fail,
    input logic              core_prog_fail,
    input logic              core_ecc_load,
    input logic [1:0]        core_ecc_val,
    input logic [BYTE_W-1:0] lock_q,
    input logic [BYTE_W-1:0] cfg_q,
    input logic              stat_erase_fail,
    input logic              stat_prog_fail,
    input logic [1:0]        stat_ecc,
    input logic              wr_en,
    input logic [BYTE_W-1:0] wr_addr,
    input logic              rst_cmd
);
    AST_ERASE_FAIL_STICKS: assert property (@(posedge clk) disable iff (rst)
        core_erase_fail |=> stat_erase_fail); // R8

    AST_PROG_FAIL_STICKS: assert property (@(posedge clk) disable iff (rst)
        core_prog_fail |=> stat_prog_fail); // R8

    AST_ECC_LOADED: assert property (@(posedge clk) disable iff (rst)
        core_ecc_load |=> (stat_ecc == $past(core_ecc_val))); // R8

    AST_LOCK_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
        !$stable(lock_q) |-> $past(wr_en && wr_addr == ADR_LOCK)); // R3

    AST_CFG_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg_q) |-> $past(wr_en && wr_addr == ADR_CFG)); // R9

    AST_FAIL_CLEARS_ONLY_BY_WIPE: assert property (@(posedge clk) disable iff (rst)
        ($fell(stat_erase_fail) || $fell(stat_prog_fail)) |-> $past(rst_cmd)); // R9
endmodule

bind nand_feat_target nfr_checker u_chk (
    .clk             (clk),
    .rst             (rst),
    .core_erase_fail (core_erase_fail),
    .core_prog_fail  (core_prog_fail),
    .core_ecc_load   (core_ecc_load),
    .core_ecc_val    (core_ecc_val),
    .lock_q          (lock_q),
    .cfg_q           (cfg_q),
    .stat_erase_fail (stat_erase_fail),
    .stat_prog_fail  (stat_prog_fail),
    .stat_ecc        (stat_ecc),
    .wr_en           (wr_en),
    .wr_addr         (wr_addr),
    .rst_cmd         (rst_cmd)
);

// File: tb/nand_feat_target_tb_top.sv
`timescale 1ns/1ps
module nand_feat_target_tb_top;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso;
    logic busy = 1'b0, efail = 1'b0, pfail = 1'b0, eload = 1'b0;
    logic [1:0] eval_v = 2'd0;
    logic [7:0] lock_q, cfg_q;
    logic otp_en, ecc_en, quad_en, st_efail, st_pfail;
    logic [1:0] st_ecc;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 1'b0;

    string      req_q[$];
    logic [7:0] exp_q[$];
    logic [7:0] act_q[$];

    always #2 clk = ~clk;

    nand_feat_target dut_i (
        .clk (clk), .rst (rst),
        .spi_sclk (sclk), .spi_cs_n (cs_n), .spi_mosi (mosi), .spi_miso (miso),
        .core_busy (busy), .core_erase_fail (efail), .core_prog_fail (pfail),
        .core_ecc_load (eload), .core_ecc_val (eval_v),
        .lock_q (lock_q), .cfg_q (cfg_q),
        .cfg_otp_en (otp_en), .cfg_ecc_en (ecc_en), .cfg_quad_en (quad_en),
        .stat_erase_fail (st_efail), .stat_prog_fail (st_pfail), .stat_ecc (st_ecc)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    // Monitor: pops read-back bytes and compares them with the queued expectations.
    initial begin
        forever begin
            @(negedge clk);
            if (act_q.size() != 0 && exp_q.size() != 0) begin
                check(req_q.pop_front(), act_q.pop_front(), exp_q.pop_front());
            end
        end
    end

    task automatic spi_bits(input logic [23:0] d, input int n, output logic [7:0] cap);
        cap = 8'h00;
        @(negedge clk);
        cs_n = 1'b0;
        for (int i = 0; i < n; i++) begin
            mosi = d[23-i];
            repeat (HALF) @(negedge clk);
            if (i >= 16) cap = {cap[6:0], miso};
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        mosi = 1'b0;
        repeat (2 * HALF) @(negedge clk);
    endtask

    task automatic rd_reg(input string req, input logic [7:0] adr, input logic [7:0] exp);
        logic [7:0] cap;
        req_q.push_back(req);
        exp_q.push_back(exp);
        spi_bits({8'h0F, adr, 8'h00}, 24, cap);
        act_q.push_back(cap);
    endtask

    task automatic wr_reg(input logic [7:0] adr, input logic [7:0] val);
        logic [7:0] cap;
        spi_bits({8'h1F, adr, val}, 24, cap);
    endtask

    task automatic pulse(input logic e, input logic p, input logic l, input logic [1:0] v);
        @(negedge clk);
        efail = e; pfail = p; eload = l; eval_v = v;
        @(negedge clk);
        efail = 1'b0; pfail = 1'b0; eload = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] cap;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R1 reset state
        check("R1 lock", lock_q, 8'h38);
        check("R1 cfg", cfg_q, 8'h10);
        check("R1 stat", {3'b0, st_efail, st_pfail, 1'b0, st_ecc}, 8'h00);
        check("R1 miso", {7'b0, miso}, 8'h00);

        // R2 reads of reset values
        rd_reg("R2 lock read", 8'hA0, 8'h38);
        rd_reg("R2 cfg read", 8'hB0, 8'h10);

        // R3 lock write
        wr_reg(8'hA0, 8'h00);
        check("R3 lock_q", lock_q, 8'h00);
        rd_reg("R3 lock readback", 8'hA0, 8'h00);

        // R4 configuration write and decoded enables
        wr_reg(8'hB0, 8'h51);
        check("R4 enables", {5'b0, otp_en, ecc_en, quad_en}, 8'h07);
        rd_reg("R4 cfg readback", 8'hB0, 8'h51);
        wr_reg(8'hB0, 8'h10);
        check("R4 enables only ecc", {5'b0, otp_en, ecc_en, quad_en}, 8'h02);
        wr_reg(8'hB0, 8'h51);

        // R5 / R8 status from core events
        busy = 1'b1;
        pulse(1'b1, 1'b0, 1'b1, 2'd2);
        check("R8 erase fail + ecc", {5'b0, st_efail, st_ecc}, 8'h06);
        rd_reg("R5 status busy/erase/uncorr", 8'hC0, 8'h25);
        busy = 1'b0;
        pulse(1'b0, 1'b1, 1'b1, 2'd1);
        check("R8 prog fail + ecc", {4'b0, st_pfail, st_efail, st_ecc}, 8'h0D);
        rd_reg("R5 status fails/corrected", 8'hC0, 8'h1C);

        // R6 status not writable
        wr_reg(8'hC0, 8'hFF);
        rd_reg("R6 status after write", 8'hC0, 8'h1C);

        // R7 unknown address
        wr_reg(8'h90, 8'h55);
        check("R7 lock untouched", lock_q, 8'h00);
        check("R7 cfg untouched", cfg_q, 8'h51);
        rd_reg("R7 unknown read", 8'h90, 8'h00);

        // R9 wipe opcode
        spi_bits({8'hFF, 16'h0000}, 8, cap);
        check("R9 fields cleared", {4'b0, st_pfail, st_efail, st_ecc}, 8'h00);
        check("R9 cfg kept", cfg_q, 8'h51);
        check("R9 lock kept", lock_q, 8'h00);
        rd_reg("R9 status read", 8'hC0, 8'h00);

        // R10 abort mid data byte, then recovery
        spi_bits({8'h1F, 8'hA0, 8'hFF}, 20, cap);
        check("R10 abort no update", lock_q, 8'h00);
        spi_bits({8'h1F, 8'hA0, 8'hFF}, 4, cap);
        wr_reg(8'hA0, 8'h7E);
        check("R10 recovered write", lock_q, 8'h7E);

        // R11 unknown opcode
        spi_bits({8'h42, 8'hA0, 8'h11}, 24, cap);
        check("R11 lock unchanged", lock_q, 8'h7E);
        check("R11 miso quiet", cap, 8'h00);

        repeat (10) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule